// File: doc/BRIEF.md
# Level-Source Interrupt Controller with Claim and Complete

This block gathers level-sensitive interrupt lines from a set of peripheral sources and presents one interrupt request per processor context. Software gives each source a small priority value and opens a per-context enable mask. Each context also has a threshold, and a source competes for a context only when its priority is strictly above that threshold. Among the competing sources, the one with the highest priority wins. A tie goes to the lower source ID.

Software services an interrupt in two steps. First it reads the context's claim register. The read returns the winning source ID, or 0 when nothing is available, and it clears that source's pending state. The source then stays blocked until software writes the same ID back to the claim register. Software can loop on claim reads, handling and completing each ID, until a read returns 0. Because claiming blocks a source and completing reopens it, the block has no separate mask or unmask registers. Source ID 0 does not exist.

Each source is guarded by a three-state gateway:
- OPEN: no pending request. A high level moves it to PENDING.
- PENDING: the request is latched. A claim moves it to CLAIMED.
- CLAIMED: the source is blocked and its level is ignored. A matching complete moves it back to OPEN, or straight to PENDING if the level is still high at that edge.

Top module: `plic_top`

## Requirements
- R1: After reset, every priority, enable bit, threshold and pending bit is 0, every irq_o bit is 0, and a claim read returns 0.
- R2: The priority of source n (1..NSRC) is at byte address 4*n and holds 3 bits; wider writes keep bits [2:0]. Address 0 (source 0) reads 0 and ignores writes.
- R3: Context c's enable word w is at 0x2000 + 0x80*c + 4*w. Source n sits in word n/32 at bit n%32. The bit for source 0, and bits for IDs above NSRC, read 0.
- R4: Context c's threshold (3 bits) is at 0x200000 + 0x1000*c, and its claim/complete register is at that address + 4.
- R5: A pending, enabled source is eligible for a context only when its priority is strictly greater than that context's threshold.
- R6: A claim returns the eligible source with the highest priority; on equal priority the lowest ID wins.
- R7: A claim read returns the winning ID and clears its pending state; with no eligible source it returns 0 and changes nothing.
- R8: A claimed source ignores its level input and cannot interrupt until completed.
- R9: Writing a claimed ID to any context's claim register reopens that source's gateway. If its level is high at that edge, the source is pending again right after it.
- R10: A complete write carrying an ID with no outstanding claim (including 0 or out-of-range values) has no effect.
- R11: Writes to unimplemented addresses (including unaligned ones) are ignored, and reads from them return 0.
- R12: irq_o[c] is high, from the clock edge after a change, exactly when context c has at least one eligible source.
- R13: bus_rdata_o is registered. It shows the read value after the edge that samples bus_rd_i, and holds its value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level interrupt lines; bit k is source ID k+1 |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | NCTX | Interrupt request per context |

## Verification
Two kinds of event are deliberately made to land on the same clock edge. In the first, a complete write arrives while the completed source's level is still high, so the gateway's reopening and the re-latching of pending fall on one edge. The bench judges this by irq_o on the next cycle and by the ID returned from a following claim read. In the second, a claim read coincides with a different source's line rising. The claim must return the winner as it stood before that edge, and the newly raised source must become pending on the same edge. A behavioural model, built on per-source flags and a linear search, predicts bus_rdata_o and irq_o every cycle through directed sequences and a long random mix of such collisions.

// File: rtl/plic_pkg.sv
package plic_pkg;

    typedef enum logic [1:0] {
        GW_OPEN    = 2'd0,
        GW_PENDING = 2'd1,
        GW_CLAIMED = 2'd2
    } gw_state_e;

    localparam int EN_BASE    = 'h2000;
    localparam int EN_STRIDE  = 'h80;
    localparam int CTX_BASE   = 'h200000;
    localparam int CTX_STRIDE = 'h1000;
    localparam int CLAIM_OFS  = 4;

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway
    import plic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o
);

    gw_state_e state_q;
    gw_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GW_OPEN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_OPEN:    if (level_i) state_d = GW_PENDING;
            GW_PENDING: if (claim_i) state_d = GW_CLAIMED;
            GW_CLAIMED: if (complete_i) state_d = level_i ? GW_PENDING : GW_OPEN;
            default:    state_d = GW_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        pending_o = (state_q == GW_PENDING);
    end

    // claims only ever hit a latched request (R7)
    p_claim_only_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |-> state_q == GW_PENDING);

    // a claimed source stays blocked until completed (R8)
    p_blocked_until_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GW_CLAIMED && !complete_i) |=> !pending_o);

    // complete with the level still high re-latches at once (R9)
    p_relatch_on_complete_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GW_CLAIMED && complete_i && level_i) |=> pending_o);

endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
    parameter int NSRC   = 40,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC:1]            pend_i,
    input  logic [NSRC:1]            en_i,
    input  logic [NSRC*PRIO_W-1:0]   prio_i,
    input  logic [PRIO_W-1:0]        thr_i,
    output logic [ID_W-1:0]          best_o,
    output logic                     irq_o
);

    logic              found;
    logic [PRIO_W-1:0] best_p;
    logic [PRIO_W-1:0] p;

    // walk from the top ID down; ">=" lets the lower ID win ties
    always_comb begin
        found  = 1'b0;
        best_p = '0;
        best_o = '0;
        p      = '0;
        for (int i = NSRC; i >= 1; i--) begin
            p = prio_i[(i-1)*PRIO_W +: PRIO_W];
            if (pend_i[i] && en_i[i] && (p > thr_i) && (!found || p >= best_p)) begin
                found  = 1'b1;
                best_p = p;
                best_o = ID_W'(i);
            end
        end
        irq_o = found;
    end

    // the winner must satisfy the threshold rule (R5)
    p_winner_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (best_o != '0) |-> (pend_i[best_o] && en_i[best_o] &&
                            prio_i[(best_o-1)*PRIO_W +: PRIO_W] > thr_i));

    // a request needs some latched source (R12)
    p_irq_needs_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|pend_i));

endmodule

// File: rtl/plic_regs.sv
module plic_regs
    import plic_pkg::*;
#(
    parameter int NSRC   = 40,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 26,
    parameter int ID_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic                     rd_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [31:0]              wdata_i,
    input  logic [NCTX*ID_W-1:0]     best_i,
    output logic [NSRC*PRIO_W-1:0]   prio_o,
    output logic [NCTX*NSRC-1:0]     en_o,
    output logic [NCTX*PRIO_W-1:0]   thr_o,
    output logic [NSRC:1]            claim_o,
    output logic [NSRC:1]            complete_o,
    output logic [31:0]              rdata_o
);

    localparam int NWORD = (NSRC + 32) / 32;
    localparam int EN_W  = NWORD * 32;
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;
    localparam int WD_W  = (NWORD > 1) ? $clog2(NWORD) : 1;

    function automatic logic [EN_W-1:0] en_mask_f();
        logic [EN_W-1:0] m;
        m = '0;
        for (int i = 1; i <= NSRC; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [EN_W-1:0] EN_MASK = en_mask_f();

    logic [PRIO_W-1:0] prio_q [1:NSRC];
    logic [EN_W-1:0]   en_q   [NCTX];
    logic [PRIO_W-1:0] thr_q  [NCTX];
    logic [31:0]       rdata_q;

    logic              prio_hit;
    logic [ID_W-1:0]   prio_sel;
    logic              en_hit;
    logic [CTX_W-1:0]  en_ctx;
    logic [WD_W-1:0]   en_word;
    logic              thr_hit;
    logic              clm_hit;
    logic [CTX_W-1:0]  ctx_sel;
    logic [31:0]       rd_val;
    logic [EN_W-1:0]   en_new;
    logic [ID_W-1:0]   clm_id;

    // address decode
    always_comb begin
        prio_hit = 1'b0;
        prio_sel = '0;
        en_hit   = 1'b0;
        en_ctx   = '0;
        en_word  = '0;
        thr_hit  = 1'b0;
        clm_hit  = 1'b0;
        ctx_sel  = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (addr_i == ADDR_W'(4 * i)) begin
                prio_hit = 1'b1;
                prio_sel = ID_W'(i);
            end
        end
        for (int c = 0; c < NCTX; c++) begin
            for (int w = 0; w < NWORD; w++) begin
                if (addr_i == ADDR_W'(EN_BASE + c * EN_STRIDE + 4 * w)) begin
                    en_hit  = 1'b1;
                    en_ctx  = CTX_W'(c);
                    en_word = WD_W'(w);
                end
            end
            if (addr_i == ADDR_W'(CTX_BASE + c * CTX_STRIDE)) begin
                thr_hit = 1'b1;
                ctx_sel = CTX_W'(c);
            end
            if (addr_i == ADDR_W'(CTX_BASE + c * CTX_STRIDE + CLAIM_OFS)) begin
                clm_hit = 1'b1;
                ctx_sel = CTX_W'(c);
            end
        end
    end

    assign clm_id = best_i[ctx_sel*ID_W +: ID_W];

    // read value
    always_comb begin
        rd_val = '0;
        if (prio_hit)      rd_val = 32'(prio_q[prio_sel]);
        else if (en_hit)   rd_val = en_q[en_ctx][en_word*32 +: 32];
        else if (thr_hit)  rd_val = 32'(thr_q[ctx_sel]);
        else if (clm_hit)  rd_val = 32'(clm_id);
    end

    // merged enable word on write
    always_comb begin
        en_new = en_q[en_ctx];
        en_new[en_word*32 +: 32] = wdata_i;
        en_new = en_new & EN_MASK;
    end

    // claim and complete strobes to the gateways
    always_comb begin
        claim_o = '0;
        if (rd_i && clm_hit && clm_id != '0) claim_o[clm_id] = 1'b1;
        for (int i = 1; i <= NSRC; i++) begin
            complete_o[i] = wr_i && clm_hit && (wdata_i == 32'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 1; i <= NSRC; i++) prio_q[i] <= '0;
            for (int c = 0; c < NCTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
            rdata_q <= '0;
        end else begin
            if (wr_i && prio_hit) prio_q[prio_sel] <= wdata_i[PRIO_W-1:0];
            if (wr_i && en_hit)   en_q[en_ctx] <= en_new;
            if (wr_i && thr_hit)  thr_q[ctx_sel] <= wdata_i[PRIO_W-1:0];
            if (rd_i)             rdata_q <= rd_val;
        end
    end

    always_comb begin
        for (int i = 1; i <= NSRC; i++) prio_o[(i-1)*PRIO_W +: PRIO_W] = prio_q[i];
        for (int c = 0; c < NCTX; c++) begin
            en_o[c*NSRC +: NSRC]       = en_q[c][NSRC:1];
            thr_o[c*PRIO_W +: PRIO_W]  = thr_q[c];
        end
    end

    assign rdata_o = rdata_q;

    // read data holds between reads (R13)
    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

    // at most one source claimed per access (R7)
    p_single_claim_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_o));

    // a claim strobe needs a read of a claim register (R7)
    p_claim_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|claim_o) |-> rd_i);

endmodule

// File: rtl/plic_top.sv
module plic_top #(
    parameter int NSRC   = 40,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic [NCTX-1:0]   irq_o
);

    localparam int ID_W = $clog2(NSRC + 1);

    logic [NSRC*PRIO_W-1:0] prio;
    logic [NCTX*NSRC-1:0]   en;
    logic [NCTX*PRIO_W-1:0] thr;
    logic [NSRC:1]          claim;
    logic [NSRC:1]          complete;
    logic [NSRC:1]          pend;
    logic [NCTX*ID_W-1:0]   best;

    plic_regs #(
        .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .ID_W(ID_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i),
        .rd_i       (bus_rd_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .best_i     (best),
        .prio_o     (prio),
        .en_o       (en),
        .thr_o      (thr),
        .claim_o    (claim),
        .complete_o (complete),
        .rdata_o    (bus_rdata_o)
    );

    for (genvar s = 1; s <= NSRC; s++) begin : g_gw
        plic_gateway u_gw (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_i    (src_i[s-1]),
            .claim_i    (claim[s]),
            .complete_i (complete[s]),
            .pending_o  (pend[s])
        );
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_arb
        plic_arbiter #(
            .NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
        ) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .pend_i (pend),
            .en_i   (en[c*NSRC +: NSRC]),
            .prio_i (prio),
            .thr_i  (thr[c*PRIO_W +: PRIO_W]),
            .best_o (best[c*ID_W +: ID_W]),
            .irq_o  (irq_o[c])
        );
    end

endmodule

// File: tb/test_plic_top.sv
`timescale 1ns/1ps
module test_plic_top;

    localparam int NSRC   = 40;
    localparam int NCTX   = 2;
    localparam int PRIO_W = 3;
    localparam int ADDR_W = 26;
    localparam int NWORD  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NCTX-1:0]   irq;

    always #2 clk = ~clk;

    plic_top #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) i_plic_top (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // behavioural model state
    int          mprio [NSRC+1];
    bit          men   [NCTX][NSRC+1];
    int          mthr  [NCTX];
    bit          mpend [NSRC+1];
    bit          mclm  [NSRC+1];
    int          mbst  [NCTX];
    logic [31:0] exp_rdata = '0;
    logic [NCTX-1:0] exp_irq = '0;
    int          checks = 0;
    int          errs = 0;
    string       cur_req = "R1";

    function automatic int a_prio(int i);       return 4 * i; endfunction
    function automatic int a_en(int c, int w);  return 'h2000 + 'h80 * c + 4 * w; endfunction
    function automatic int a_thr(int c);        return 'h200000 + 'h1000 * c; endfunction
    function automatic int a_clm(int c);        return 'h200000 + 'h1000 * c + 4; endfunction

    // linear search, lowest ID first, strict improvement only
    function automatic int mbest(int c);
        int b = 0;
        int bp = -1;
        for (int i = 1; i <= NSRC; i++)
            if (mpend[i] && men[c][i] && mprio[i] > mthr[c] && mprio[i] > bp) begin
                b = i;
                bp = mprio[i];
            end
        return b;
    endfunction

    function automatic logic [31:0] mread(int a);
        logic [31:0] v = '0;
        for (int i = 1; i <= NSRC; i++) if (a == a_prio(i)) v = mprio[i];
        for (int c = 0; c < NCTX; c++) begin
            for (int w = 0; w < NWORD; w++)
                if (a == a_en(c, w))
                    for (int b = 0; b < 32; b++)
                        if (w * 32 + b >= 1 && w * 32 + b <= NSRC) v[b] = men[c][w * 32 + b];
            if (a == a_thr(c)) v = mthr[c];
            if (a == a_clm(c)) v = mbst[c];
        end
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        int a;
        if (!rst_n) begin
            for (int i = 0; i <= NSRC; i++) begin
                mprio[i] = 0; mpend[i] = 0; mclm[i] = 0;
                for (int c = 0; c < NCTX; c++) men[c][i] = 0;
            end
            for (int c = 0; c < NCTX; c++) begin mthr[c] = 0; mbst[c] = 0; end
            exp_rdata = '0;
            exp_irq = '0;
        end else begin
            a = int'(addr);
            for (int c = 0; c < NCTX; c++) mbst[c] = mbest(c);
            if (rd) begin
                exp_rdata = mread(a);
                for (int c = 0; c < NCTX; c++)
                    if (a == a_clm(c) && mbst[c] != 0) begin
                        mpend[mbst[c]] = 0;
                        mclm[mbst[c]] = 1;
                    end
            end
            if (wr) begin
                for (int i = 1; i <= NSRC; i++) if (a == a_prio(i)) mprio[i] = wdata & 7;
                for (int c = 0; c < NCTX; c++) begin
                    for (int w = 0; w < NWORD; w++)
                        if (a == a_en(c, w))
                            for (int b = 0; b < 32; b++)
                                if (w * 32 + b >= 1 && w * 32 + b <= NSRC) men[c][w * 32 + b] = wdata[b];
                    if (a == a_thr(c)) mthr[c] = wdata & 7;
                    if (a == a_clm(c) && wdata >= 1 && wdata <= NSRC && mclm[wdata]) begin
                        mclm[wdata] = 0;
                        mpend[wdata] = src[wdata - 1];
                    end
                end
            end
            for (int i = 1; i <= NSRC; i++) if (!mclm[i] && src[i - 1]) mpend[i] = 1;
            for (int c = 0; c < NCTX; c++) exp_irq[c] = (mbest(c) != 0);
        end
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s at %0t: actual 0x%0h expected 0x%0h", req, what, $time, act, exp);
        end
    endtask

    // compare on every clock, away from the rising edge
    always @(negedge clk) begin
        check(rdata === exp_rdata, cur_req, "rdata", rdata, exp_rdata);
        check(irq === exp_irq, "R12", "irq", 32'(irq), 32'(exp_irq));
    end

    task automatic bus_w(int a, logic [31:0] d);
        wr = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_r(int a);
        rd = 1'b1; addr = ADDR_W'(a);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL R12 watchdog expired");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1: reset values
        cur_req = "R1";
        bus_r(a_prio(5)); bus_r(a_en(0, 0)); bus_r(a_thr(1)); bus_r(a_clm(0));
        check(rdata == 0, "R1", "claim after reset", rdata, 0);

        // R2: priority storage, width, source 0
        cur_req = "R2";
        bus_w(a_prio(3), 7); bus_w(a_prio(5), 32'hFF); bus_w(0, 5);
        bus_r(a_prio(3)); bus_r(a_prio(5));
        check(rdata == 7, "R2", "masked priority", rdata, 7);
        bus_r(0);
        check(rdata == 0, "R2", "source 0 priority", rdata, 0);

        // R3: enable packing, bit 0 and bits above NSRC read 0
        cur_req = "R3";
        bus_w(a_en(0, 0), 32'hFFFF_FFFF); bus_w(a_en(0, 1), 32'hFFFF_FFFF);
        bus_r(a_en(0, 0));
        check(rdata == 32'hFFFF_FFFE, "R3", "enable word 0", rdata, 32'hFFFF_FFFE);
        bus_r(a_en(0, 1));
        check(rdata == 32'h1FF, "R3", "enable word 1", rdata, 32'h1FF);
        bus_r(a_en(1, 0));

        // R11: unimplemented addresses
        cur_req = "R11";
        bus_w('h1000, 32'h3); bus_w(a_en(2, 0), 32'hFF); bus_w(a_prio(3) + 1, 0);
        bus_r('h1000); bus_r(a_en(2, 0)); bus_r(a_prio(3) + 1); bus_r(a_thr(2));
        check(rdata == 0, "R11", "unmapped read", rdata, 0);
        bus_r(a_prio(3));

        // R4: thresholds per context
        cur_req = "R4";
        bus_w(a_thr(0), 3); bus_w(a_thr(1), 32'hE);
        bus_r(a_thr(0)); bus_r(a_thr(1));
        check(rdata == 6, "R4", "threshold 1", rdata, 6);

        // R5: strict threshold rule
        cur_req = "R5";
        bus_w(a_en(0, 0), 0); bus_w(a_en(0, 1), 0);
        bus_w(a_prio(3), 2); bus_w(a_en(0, 0), 32'h8); bus_w(a_thr(0), 2);
        src[2] = 1'b1;
        idle(3);
        check(irq[0] == 0, "R5", "prio equal to threshold", 32'(irq[0]), 0);
        bus_w(a_thr(0), 1);
        idle(1);
        check(irq[0] == 1, "R5", "prio above threshold", 32'(irq[0]), 1);

        // R7: claim, then empty claim
        cur_req = "R7";
        bus_r(a_clm(0));
        check(rdata == 3, "R7", "claim id", rdata, 3);
        bus_r(a_clm(0));
        check(rdata == 0, "R7", "empty claim", rdata, 0);

        // R8: blocked while claimed, level held high
        cur_req = "R8";
        idle(3);
        check(irq[0] == 0, "R8", "blocked source", 32'(irq[0]), 0);

        // R10: stray completes
        cur_req = "R10";
        bus_w(a_clm(0), 5); bus_w(a_clm(0), 0); bus_w(a_clm(0), 32'h1_0003);
        idle(2);
        check(irq[0] == 0, "R10", "stray complete", 32'(irq[0]), 0);

        // R9: complete with level still high re-latches on the same edge
        cur_req = "R9";
        bus_w(a_clm(1), 3);
        check(irq[0] == 1, "R9", "relatched", 32'(irq[0]), 1);
        bus_r(a_clm(0));
        check(rdata == 3, "R9", "reclaim", rdata, 3);
        src[2] = 1'b0;
        bus_w(a_clm(0), 3);
        idle(2);

        // R6: highest priority, ties to lowest ID, across enable words
        cur_req = "R6";
        bus_w(a_thr(1), 0);
        bus_w(a_prio(10), 5); bus_w(a_prio(33), 5); bus_w(a_prio(20), 6);
        bus_w(a_en(1, 0), (32'h1 << 10) | (32'h1 << 20)); bus_w(a_en(1, 1), 32'h2);
        src[9] = 1'b1; src[32] = 1'b1; src[19] = 1'b1;
        idle(2);
        bus_r(a_clm(1));
        check(rdata == 20, "R6", "highest priority", rdata, 20);
        bus_r(a_clm(1));
        check(rdata == 10, "R6", "tie to lowest id", rdata, 10);
        bus_r(a_clm(1));
        check(rdata == 33, "R6", "remaining", rdata, 33);
        src[9] = 1'b0; src[32] = 1'b0; src[19] = 1'b0;
        bus_w(a_clm(1), 20); bus_w(a_clm(1), 10); bus_w(a_clm(1), 33);

        // R9: claim read on the edge where another line rises
        cur_req = "R9";
        bus_w(a_prio(7), 1); bus_w(a_en(1, 0), (32'h1 << 7) | (32'h1 << 20));
        src[19] = 1'b1;
        idle(2);
        rd = 1'b1; addr = ADDR_W'(a_clm(1)); src[6] = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check(rdata == 20, "R9", "claim beside rising line", rdata, 20);
        bus_r(a_clm(1));
        check(rdata == 7, "R9", "new source pending", rdata, 7);
        src = '0;
        bus_w(a_clm(1), 20); bus_w(a_clm(1), 7);

        // R12 and R13: random mix, model compared every cycle
        cur_req = "R13";
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 9;
            int c = $urandom % NCTX;
            case (r)
                0: bus_w(a_prio(1 + $urandom % NSRC), $urandom);
                1: bus_w(a_en(c, $urandom % NWORD), $urandom);
                2: bus_w(a_thr(c), $urandom % 4);
                3, 4: bus_r(a_clm(c));
                5: bus_w(a_clm(c), $urandom % (NSRC + 3));
                6: begin src[$urandom % NSRC] ^= 1'b1; idle(1); end
                7: bus_r(a_prio($urandom % (NSRC + 2)));
                default: begin
                    rd = 1'b1; addr = ADDR_W'(a_clm(c));
                    src[$urandom % NSRC] ^= 1'b1;
                    @(negedge clk);
                    rd = 1'b0;
                end
            endcase
        end
        idle(2);
        finish_run();
    end

endmodule